// File: doc/BRIEF.md
# Word Stack Push/Pop Engine

This block moves 16-bit words between a byte-wide, single-port stack memory and the rest of a processor datapath. It holds the stack pointer, splits each word into two byte cycles on the memory port, and runs six commands: push one word, pop one word, save the whole eight-entry register set, restore it, and push or pop a single flags word.

A command is offered with `cmd_valid` and an opcode while the engine is idle. The engine raises `busy` and steps through the byte cycles. It then pulses `done` for one cycle. For pops, the result is on `pop_data` in that same cycle. The register set sits outside the engine: the engine reads it through a combinational read port and writes it through a one-cycle write strobe. The flags word arrives on `flags_in`, and a restored flags word is announced with `flags_we`. The stack pointer can be overwritten from outside while the engine is idle.

The memory answers a read one cycle after `mem_re`. Writes take effect at the clock edge that ends the `mem_we` cycle.

Top module: `wstk_engine`

## Requirements
- R1: After reset, `busy` and `done` are low and `sp_out` equals 0x0000.
- R2: With `sp_load` high in an idle cycle, `sp_out` takes `sp_load_val` at that edge. If `cmd_valid` is high in the same cycle, that command is dropped.
- R3: Opcode 0 pushes `cmd_data`. The first cycle writes the high byte at SP-1 and the next cycle writes the low byte at SP-2. That is exactly two memory writes, and no cycle has both `mem_we` and `mem_re` high.
- R4: A push leaves SP lowered by 2. `done` is high for exactly one cycle, two edges after the accepting edge.
- R5: Opcode 1 reads SP and then SP+1. It returns `pop_data` = {byte at SP+1, byte at SP}, raises SP by 2, and pulses `done` three edges after the accepting edge.
- R6: All stack pointer and address arithmetic wraps modulo 65536.
- R7: Opcode 2 pushes register indices 0 through 7 in ascending order. Index 4 is replaced by the SP value held when the command was taken. SP drops by 16, and `done` comes 16 edges after acceptance.
- R8: Opcode 3 pops eight words and writes them to indices 7 down to 0 through `reg_we`/`reg_widx`/`reg_wdata`. The word for index 4 is thrown away and never written. SP rises by 16, and `done` comes 24 edges after acceptance.
- R9: Opcode 4 pushes `flags_in` with push timing. Opcode 5 pops a word with pop timing and raises `flags_we` together with `done`. No other command raises `flags_we`.
- R10: `busy` is high from the accepting edge until the `done` cycle. While it is high, `cmd_valid` and `sp_load` have no effect.
- R11: Opcodes 6 and 7 are ignored. They cause no busy, no memory access and no SP change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 3 | Command opcode (0..5 defined) |
| cmd_data | input | 16 | Word for a single push |
| flags_in | input | 16 | Flags word for the flags push |
| sp_load | input | 1 | Overwrite the stack pointer |
| sp_load_val | input | 16 | New stack pointer value |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| pop_data | output | 16 | Word returned by a pop |
| flags_we | output | 1 | Popped word is the flags word |
| sp_out | output | 16 | Current stack pointer |
| reg_rd_idx | output | 3 | Register set read index |
| reg_rd_data | input | 16 | Register set read data |
| reg_we | output | 1 | Register set write strobe |
| reg_widx | output | 3 | Register set write index |
| reg_wdata | output | 16 | Register set write data |
| mem_addr | output | 16 | Byte address |
| mem_we | output | 1 | Byte write |
| mem_re | output | 1 | Byte read |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid one cycle after mem_re |

## Verification
Results are due at fixed distances from the accepting edge: 2 edges for a single push or flags push, 3 for a pop or flags pop, 16 for a full save and 24 for a full restore. The bench stamps each command with the cycle of its accepting edge and stores the latency it expects, along with the SP and data. A monitor that samples on falling edges compares the measured distance whenever `done` rises. Memory bytes and register-set contents are read from the bench's own models only after `done`, because the last write lands on the edge after the strobe.

// File: rtl/wstk_pkg.sv
package wstk_pkg;

    parameter int unsigned WSTK_WORD_W = 16;
    parameter int unsigned WSTK_ADDR_W = 16;
    parameter int unsigned WSTK_NREG   = 8;

    typedef enum logic [2:0] {
        OP_PUSH     = 3'd0,
        OP_POP      = 3'd1,
        OP_PUSHALL  = 3'd2,
        OP_POPALL   = 3'd3,
        OP_PUSHFLG  = 3'd4,
        OP_POPFLG   = 3'd5
    } wstk_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_HI,
        ST_WR_LO,
        ST_RD_LO,
        ST_RD_HI,
        ST_RD_WAIT
    } wstk_st_e;

endpackage

// File: rtl/wstk_order.sv
module wstk_order #(
    parameter int unsigned NREG  = 8,
    localparam int unsigned IDX_W = $clog2(NREG)
) (
    input  logic [IDX_W-1:0] cnt,
    input  logic             rev,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NREG - 1);

    always_comb begin
        idx = rev ? (TOP_IDX - cnt) : cnt;
    end
endmodule

// File: rtl/wstk_mem_if.sv
module wstk_mem_if
    import wstk_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned ADDR_W = 16,
    localparam int unsigned BYTE_W = WORD_W / 2
) (
    input  wstk_st_e          st,
    input  logic [ADDR_W-1:0] sp,
    input  logic [WORD_W-1:0] push_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [BYTE_W-1:0] mem_wdata
);
    always_comb begin
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = '0;
        case (st)
            ST_WR_HI: begin
                mem_addr  = sp - ADDR_W'(1);
                mem_we    = 1'b1;
                mem_wdata = push_word[WORD_W-1:BYTE_W];
            end
            ST_WR_LO: begin
                mem_addr  = sp - ADDR_W'(2);
                mem_we    = 1'b1;
                mem_wdata = push_word[BYTE_W-1:0];
            end
            ST_RD_LO: begin
                mem_addr = sp;
                mem_re   = 1'b1;
            end
            ST_RD_HI: begin
                mem_addr = sp + ADDR_W'(1);
                mem_re   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wstk_ctrl.sv
module wstk_ctrl
    import wstk_pkg::*;
#(
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned NREG     = 8,
    parameter int unsigned SP_IDX   = 4,
    parameter logic [ADDR_W-1:0] RESET_SP = '0,
    localparam int unsigned BYTE_W = WORD_W / 2,
    localparam int unsigned IDX_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic [WORD_W-1:0] flags_in,
    input  logic              sp_load,
    input  logic [ADDR_W-1:0] sp_load_val,
    input  logic [IDX_W-1:0]  cur_idx,
    input  logic [WORD_W-1:0] reg_rd_data,
    input  logic [BYTE_W-1:0] mem_rdata,
    output wstk_st_e          st,
    output logic [ADDR_W-1:0] sp,
    output logic [IDX_W-1:0]  cnt,
    output logic              rev,
    output logic [WORD_W-1:0] push_word,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] res_word,
    output logic              reg_we,
    output logic [IDX_W-1:0]  reg_widx,
    output logic              flags_we
);
    localparam logic [IDX_W-1:0]  LAST_CNT = IDX_W'(NREG - 1);
    localparam logic [IDX_W-1:0]  SP_SLOT  = IDX_W'(SP_IDX);
    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(2);

    typedef struct packed {
        wstk_st_e          st;
        wstk_op_e          op;
        logic [ADDR_W-1:0] sp;
        logic [ADDR_W-1:0] orig;
        logic [IDX_W-1:0]  cnt;
        logic [BYTE_W-1:0] lo;
        logic [WORD_W-1:0] wdat;
        logic [WORD_W-1:0] res;
        logic              done;
        logic              reg_we;
        logic [IDX_W-1:0]  widx;
        logic              flags_we;
    } ctrl_s;

    ctrl_s st_d, st_q;
    logic [WORD_W-1:0] got_word;

    always_comb begin
        got_word = {mem_rdata, st_q.lo};
        st_d          = st_q;
        st_d.done     = 1'b0;
        st_d.reg_we   = 1'b0;
        st_d.flags_we = 1'b0;
        case (st_q.st)
            ST_IDLE: begin
                if (sp_load) begin
                    st_d.sp = sp_load_val;
                end else if (cmd_valid) begin
                    st_d.cnt  = '0;
                    st_d.orig = st_q.sp;
                    case (cmd_op)
                        OP_PUSH: begin
                            st_d.op   = OP_PUSH;
                            st_d.wdat = cmd_data;
                            st_d.st   = ST_WR_HI;
                        end
                        OP_PUSHFLG: begin
                            st_d.op   = OP_PUSHFLG;
                            st_d.wdat = flags_in;
                            st_d.st   = ST_WR_HI;
                        end
                        OP_PUSHALL: begin
                            st_d.op = OP_PUSHALL;
                            st_d.st = ST_WR_HI;
                        end
                        OP_POP: begin
                            st_d.op = OP_POP;
                            st_d.st = ST_RD_LO;
                        end
                        OP_POPFLG: begin
                            st_d.op = OP_POPFLG;
                            st_d.st = ST_RD_LO;
                        end
                        OP_POPALL: begin
                            st_d.op = OP_POPALL;
                            st_d.st = ST_RD_LO;
                        end
                        default: ;
                    endcase
                end
            end
            ST_WR_HI: begin
                st_d.st = ST_WR_LO;
            end
            ST_WR_LO: begin
                st_d.sp = st_q.sp - STEP;
                if (st_q.op == OP_PUSHALL && st_q.cnt != LAST_CNT) begin
                    st_d.cnt = st_q.cnt + IDX_W'(1);
                    st_d.st  = ST_WR_HI;
                end else begin
                    st_d.st   = ST_IDLE;
                    st_d.done = 1'b1;
                end
            end
            ST_RD_LO: begin
                st_d.st = ST_RD_HI;
            end
            ST_RD_HI: begin
                st_d.lo = mem_rdata;
                st_d.st = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                st_d.sp  = st_q.sp + STEP;
                st_d.res = got_word;
                if (st_q.op == OP_POPALL) begin
                    st_d.widx   = cur_idx;
                    st_d.reg_we = (cur_idx != SP_SLOT);
                    if (st_q.cnt != LAST_CNT) begin
                        st_d.cnt = st_q.cnt + IDX_W'(1);
                        st_d.st  = ST_RD_LO;
                    end else begin
                        st_d.st   = ST_IDLE;
                        st_d.done = 1'b1;
                    end
                end else begin
                    st_d.flags_we = (st_q.op == OP_POPFLG);
                    st_d.st       = ST_IDLE;
                    st_d.done     = 1'b1;
                end
            end
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.st       <= ST_IDLE;
            st_q.op       <= OP_PUSH;
            st_q.sp       <= RESET_SP;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st       = st_q.st;
        sp       = st_q.sp;
        cnt      = st_q.cnt;
        rev      = (st_q.op == OP_POPALL);
        busy     = (st_q.st != ST_IDLE);
        done     = st_q.done;
        res_word = st_q.res;
        reg_we   = st_q.reg_we;
        reg_widx = st_q.widx;
        flags_we = st_q.flags_we;
        if (st_q.op == OP_PUSHALL)
            push_word = (cur_idx == SP_SLOT) ? WORD_W'(st_q.orig) : reg_rd_data;
        else
            push_word = st_q.wdat;
    end

    // R4: a word push lowers SP by two when its low byte is written
    a_r4_push_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == ST_WR_LO) |=> (st_q.sp == $past(st_q.sp) - STEP));

    // R5: a word pop raises SP by two once its high byte returns
    a_r5_pop_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == ST_RD_WAIT) |=> (st_q.sp == $past(st_q.sp) + STEP));

    // R3: high-byte write is always followed by the low-byte write
    a_r3_byte_order: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == ST_WR_HI) |=> (st_q.st == ST_WR_LO));

    // R4: done lasts a single cycle
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R10: busy is low in the done cycle
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (st_q.st == ST_IDLE));

    // R10: SP does not move while busy except by the command's own steps
    a_r10_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == ST_WR_HI || st_q.st == ST_RD_LO || st_q.st == ST_RD_HI)
        |=> $stable(st_q.sp));
endmodule

// File: rtl/wstk_engine.sv
module wstk_engine
    import wstk_pkg::*;
#(
    parameter int unsigned WORD_W = WSTK_WORD_W,
    parameter int unsigned ADDR_W = WSTK_ADDR_W,
    parameter int unsigned NREG   = WSTK_NREG,
    parameter int unsigned SP_IDX = 4,
    parameter logic [ADDR_W-1:0] RESET_SP = '0,
    localparam int unsigned BYTE_W = WORD_W / 2,
    localparam int unsigned IDX_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic [WORD_W-1:0] flags_in,
    input  logic              sp_load,
    input  logic [ADDR_W-1:0] sp_load_val,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] pop_data,
    output logic              flags_we,
    output logic [ADDR_W-1:0] sp_out,
    output logic [IDX_W-1:0]  reg_rd_idx,
    input  logic [WORD_W-1:0] reg_rd_data,
    output logic              reg_we,
    output logic [IDX_W-1:0]  reg_widx,
    output logic [WORD_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata
);
    wstk_st_e          st;
    logic [ADDR_W-1:0] sp;
    logic [IDX_W-1:0]  cnt;
    logic              rev;
    logic [IDX_W-1:0]  cur_idx;
    logic [WORD_W-1:0] push_word;
    logic [WORD_W-1:0] res_word;

    wstk_order #(.NREG(NREG)) u_order (
        .cnt (cnt),
        .rev (rev),
        .idx (cur_idx)
    );

    wstk_ctrl #(
        .WORD_W  (WORD_W),
        .ADDR_W  (ADDR_W),
        .NREG    (NREG),
        .SP_IDX  (SP_IDX),
        .RESET_SP(RESET_SP)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_data   (cmd_data),
        .flags_in   (flags_in),
        .sp_load    (sp_load),
        .sp_load_val(sp_load_val),
        .cur_idx    (cur_idx),
        .reg_rd_data(reg_rd_data),
        .mem_rdata  (mem_rdata),
        .st         (st),
        .sp         (sp),
        .cnt        (cnt),
        .rev        (rev),
        .push_word  (push_word),
        .busy       (busy),
        .done       (done),
        .res_word   (res_word),
        .reg_we     (reg_we),
        .reg_widx   (reg_widx),
        .flags_we   (flags_we)
    );

    wstk_mem_if #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mem_if (
        .st       (st),
        .sp       (sp),
        .push_word(push_word),
        .mem_addr (mem_addr),
        .mem_we   (mem_we),
        .mem_re   (mem_re),
        .mem_wdata(mem_wdata)
    );

    always_comb begin
        sp_out     = sp;
        reg_rd_idx = cur_idx;
        pop_data   = res_word;
        reg_wdata  = res_word;
    end

    // R3: one memory access per cycle at most
    a_r3_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R8: the saved-SP slot is never written back into the register set
    a_r8_skip_sp_slot: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (reg_widx != IDX_W'(SP_IDX)));

    // R9: flags strobe only comes with done
    a_r9_flags_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> done);
endmodule

// File: tb/wstk_engine_bench.sv
`timescale 1ns/1ps
module wstk_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [15:0] cmd_data = 16'h0;
    logic [15:0] flags_in = 16'h0;
    logic        sp_load = 1'b0;
    logic [15:0] sp_load_val = 16'h0;
    logic        busy, done, flags_we, reg_we, mem_we, mem_re;
    logic [15:0] pop_data, sp_out, reg_wdata, mem_addr;
    logic [2:0]  reg_rd_idx, reg_widx;
    logic [15:0] reg_rd_data;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h0;

    always #2.5 clk = ~clk;

    wstk_engine u_wstk_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .flags_in(flags_in), .sp_load(sp_load),
        .sp_load_val(sp_load_val), .busy(busy), .done(done), .pop_data(pop_data),
        .flags_we(flags_we), .sp_out(sp_out), .reg_rd_idx(reg_rd_idx),
        .reg_rd_data(reg_rd_data), .reg_we(reg_we), .reg_widx(reg_widx),
        .reg_wdata(reg_wdata), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory and register-set models
    bit   [7:0]  mem [int unsigned];
    logic [15:0] regs [8];
    int          wr_cnt = 0;
    int          cyc = 0;
    assign reg_rd_data = regs[reg_rd_idx];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_we) begin
            mem[int'(mem_addr)] = mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_re) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
        if (reg_we) regs[reg_widx] <= reg_wdata;
    end

    int checks = 0;
    int fails  = 0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    typedef struct {
        int          start;
        int          lat;
        logic [15:0] sp;
        logic [15:0] data;
        bit          has_data;
        bit          flg;
        string       req;
    } exp_t;
    exp_t sbq[$];

    // monitor: compare every done against the oldest expectation
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sbq.size() == 0) begin
                chk("R10", "unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t it;
                it = sbq.pop_front();
                chk(it.req, "latency", 32'(cyc - it.start), 32'(it.lat));
                chk(it.req, "sp", {16'h0, sp_out}, {16'h0, it.sp});
                if (it.has_data) chk(it.req, "pop_data", {16'h0, pop_data}, {16'h0, it.data});
                chk("R9", "flags_we", {31'h0, flags_we}, {31'h0, it.flg});
            end
        end
    end

    task automatic wait_empty();
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input logic [2:0] op, input logic [15:0] d, input int lat,
                         input logic [15:0] esp, input logic [15:0] edata,
                         input bit hd, input bit flg, input string req);
        exp_t it;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        it.start = cyc; it.lat = lat; it.sp = esp; it.data = edata;
        it.has_data = hd; it.flg = flg; it.req = req;
        sbq.push_back(it);
        wait_empty();
    endtask

    task automatic load_sp(input logic [15:0] v);
        @(negedge clk);
        sp_load = 1'b1; sp_load_val = v;
        @(negedge clk);
        sp_load = 1'b0;
        chk("R2", "sp after load", {16'h0, sp_out}, {16'h0, v});
    endtask

    function automatic logic [31:0] mb(input int unsigned a);
        return {24'h0, (mem.exists(a) ? mem[a] : 8'h00)};
    endfunction

    bit finished = 1'b0;

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int w0;
        logic [15:0] saved [8];
        for (int i = 0; i < 8; i++) regs[i] = 16'h0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "busy in reset", {31'h0, busy}, 32'd0);
        chk("R1", "done in reset", {31'h0, done}, 32'd0);
        chk("R1", "sp in reset", {16'h0, sp_out}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 load, then load beats a same-cycle command
        load_sp(16'h0100);
        @(negedge clk);
        sp_load = 1'b1; sp_load_val = 16'h0400; cmd_valid = 1'b1; cmd_op = 3'd0;
        @(negedge clk);
        sp_load = 1'b0; cmd_valid = 1'b0;
        chk("R2", "sp priority load", {16'h0, sp_out}, 32'h0400);
        chk("R2", "command dropped", {31'h0, busy}, 32'd0);
        load_sp(16'h0100);

        // R3 R4 push two words
        w0 = wr_cnt;
        issue(3'd0, 16'hA1B2, 2, 16'h00FE, 16'h0, 0, 0, "R4");
        chk("R3", "write count", 32'(wr_cnt - w0), 32'd2);
        issue(3'd0, 16'h3C4D, 2, 16'h00FC, 16'h0, 0, 0, "R4");
        chk("R3", "hi byte at sp-1", mb(16'h00FF), 32'hA1);
        chk("R3", "lo byte at sp-2", mb(16'h00FE), 32'hB2);
        chk("R3", "2nd hi", mb(16'h00FD), 32'h3C);
        chk("R3", "2nd lo", mb(16'h00FC), 32'h4D);

        // R5 pops in LIFO order
        issue(3'd1, 16'h0, 3, 16'h00FE, 16'h3C4D, 1, 0, "R5");
        issue(3'd1, 16'h0, 3, 16'h0100, 16'hA1B2, 1, 0, "R5");

        // R6 wrap across zero
        load_sp(16'h0001);
        issue(3'd0, 16'h1234, 2, 16'hFFFF, 16'h0, 0, 0, "R6");
        chk("R6", "hi at 0x0000", mb(16'h0000), 32'h12);
        chk("R6", "lo at 0xFFFF", mb(16'hFFFF), 32'h34);
        issue(3'd1, 16'h0, 3, 16'h0001, 16'h1234, 1, 0, "R6");

        // R7 save the register set
        for (int i = 0; i < 8; i++) begin
            saved[i] = 16'(16'h1100 * (i + 1) + i);
            regs[i] = saved[i];
        end
        regs[4] = 16'hEEEE;
        load_sp(16'h0200);
        issue(3'd2, 16'h0, 16, 16'h01F0, 16'h0, 0, 0, "R7");
        for (int k = 0; k < 8; k++) begin
            logic [15:0] ev;
            ev = (k == 4) ? 16'h0200 : saved[k];
            chk("R7", $sformatf("slot %0d", k),
                {mb(32'(16'h0200 - 2*k - 1)) << 8} | mb(32'(16'h0200 - 2*k - 2)),
                {16'h0, ev});
        end

        // R8 restore, corrupting the saved SP slot first
        mem[32'h01F7] = 8'hDE;
        mem[32'h01F6] = 8'hAD;
        for (int i = 0; i < 8; i++) regs[i] = 16'h0;
        regs[4] = 16'hEEEE;
        issue(3'd3, 16'h0, 24, 16'h0200, 16'h0, 0, 0, "R8");
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            if (k == 4) chk("R8", "sp slot untouched", {16'h0, regs[4]}, 32'hEEEE);
            else chk("R8", $sformatf("reg %0d", k), {16'h0, regs[k]}, {16'h0, saved[k]});
        end

        // R9 flags word
        flags_in = 16'h0F5A;
        issue(3'd4, 16'h0, 2, 16'h01FE, 16'h0, 0, 0, "R9");
        flags_in = 16'h0000;
        issue(3'd5, 16'h0, 3, 16'h0200, 16'h0F5A, 1, 1, "R9");

        // R10 commands and loads ignored while busy
        begin
            exp_t it;
            @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 3'd0; cmd_data = 16'h5A5A;
            @(negedge clk);
            it.start = cyc; it.lat = 2; it.sp = 16'h01FE; it.data = 16'h0;
            it.has_data = 0; it.flg = 0; it.req = "R10";
            sbq.push_back(it);
            chk("R10", "busy after accept", {31'h0, busy}, 32'd1);
            cmd_op = 3'd1; sp_load = 1'b1; sp_load_val = 16'h5555;
            @(negedge clk);
            cmd_valid = 1'b0; sp_load = 1'b0;
            wait_empty();
            repeat (5) @(negedge clk);
            chk("R10", "sp after ignored", {16'h0, sp_out}, 32'h01FE);
            chk("R10", "pushed word hi", mb(32'h01FF), 32'h5A);
        end

        // R11 undefined opcodes
        for (int op = 6; op < 8; op++) begin
            int wc;
            wc = wr_cnt;
            @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 3'(op);
            @(negedge clk);
            cmd_valid = 1'b0;
            chk("R11", "no busy", {31'h0, busy}, 32'd0);
            repeat (4) begin
                chk("R11", "no access", {30'h0, mem_we, mem_re}, 32'd0);
                @(negedge clk);
            end
            chk("R11", "sp unchanged", {16'h0, sp_out}, 32'h01FE);
            chk("R11", "no writes", 32'(wr_cnt - wc), 32'd0);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule